// File: doc/BRIEF.md
# Receive Byte Queue with Flag-Driven Interrupt

This block sits between a pulse-width encoder and a processor bus. The encoder hands over one run-length byte at a time with a write strobe, and a single-cycle pulse when a packet of pulses has finished. The bytes wait in a small first-in first-out store until software pulls them out one at a time through a data register.

Three sticky event flags tell software what happened: bytes were lost because the store was full, a packet finished, or the fill level rose above a programmable trigger. Each flag has an enable bit in a separate enable register. The interrupt line is high while any flag is set together with its enable. Software clears a flag by writing a one to its position in the status register. The status register also shows the current number of stored bytes. The trigger is usually set to half the store depth minus one, so the interrupt fires before the store can overflow.

Top module: `rxq_irq_top`

## Requirements
- R1: After a synchronous active-low reset, the store is empty, all three flags are clear, the enable register and trigger level read as zero, `irq` is low and `reg_rdata` is zero.
- R2: Bytes leave in the order they were accepted. Each read of the data register (address 0) pops exactly one byte. The status register (address 2) reports the fill count in bits [8 +: CNT_W], where CNT_W = log2(DEPTH)+1.
- R3: A data register read while the store is empty returns zero and leaves the count at zero.
- R4: A byte that arrives while the store holds DEPTH bytes, with no pop in the same cycle, is dropped. The count stays the same and the overflow flag (status bit 0) is set.
- R5: A packet-end pulse sets the packet-end flag (status bit 1).
- R6: While the fill count is strictly greater than the trigger level (enable register bits [8 +: CNT_W]), the data-available flag (status bit 4) becomes set one cycle later. At or below the level, it is not set by the count.
- R7: Writing the status register clears each flag whose bit is written as one, and leaves the others alone. Writing 0xFF clears all three. A set condition in the same cycle wins over the clear, so data-available stays set while the count is still above the level. Writes to the count field have no effect.
- R8: `irq` is high exactly when a flag is set and its enable bit is also set. The enable bits sit at the same positions as the flags: bit 0 for overflow, bit 1 for packet end, bit 4 for data available.
- R9: The enable register (address 1) reads back the three enable bits and the trigger level at their write positions. Address 3 reads zero.
- R10: `reg_rdata` is registered. It carries the read result in the cycle after `reg_rd` is sampled, and is zero in cycles that follow no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_byte_vld | input | 1 | Encoder byte strobe |
| in_byte | input | 8 | Run-length byte from the encoder |
| in_pkt_end | input | 1 | Packet-end pulse from the encoder |
| reg_addr | input | 2 | Register select: 0 data, 1 enable, 2 status, 3 spare |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The bench fills the store past its last slot and then drains it through a scoreboard. A design that stored the extra byte, or overwrote an old one, would deliver an unexpected byte or the wrong count. It reads from an empty store, where a broken design would return stale data or wrap the count below zero. It tries to clear the data-available flag while the count is still above the trigger level; a design that gave the clear priority would lose that event. It also walks the count across the trigger level, where an off-by-one comparison would raise the flag one byte early. Finally it writes into the count field and writes ones to flags that are not set, which a sloppy decode would let change state.

// File: rtl/rxq_pkg.sv
// Package: shared register layout for the receive byte queue.
// Assumes: register addresses are word selects, 2 bits wide.
package rxq_pkg;
    localparam int OVF_POS   = 0;  // overflow flag / enable position
    localparam int PEND_POS  = 1;  // packet-end flag / enable position
    localparam int AVAIL_POS = 4;  // data-available flag / enable position
    localparam int FIELD_POS = 8;  // count / trigger field start

    typedef enum logic [1:0] {
        SEL_DATA   = 2'd0,
        SEL_ENABLE = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/rxq_store.sv
// Module: rxq_store
// Byte FIFO with a fill count. A push is refused when the FIFO is full and
// no pop happens in the same cycle. A pop from an empty FIFO yields zero.
// Assumes: DEPTH is a power of two; pop_data is valid in the cycle of pop.
module rxq_store #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic [CNT_W-1:0]  fill,
    output logic              drop
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic              is_full;
    logic              is_empty;
    logic              pop_ok;
    logic              push_ok;

    // Qualify push and pop against the current fill.
    always_comb begin
        is_full  = (fill == CNT_W'(DEPTH));
        is_empty = (fill == '0);
        pop_ok   = pop && !is_empty;
        push_ok  = push && (!is_full || pop_ok);
        drop     = push && !push_ok;
        pop_data = is_empty ? '0 : mem[rd_ptr];
    end

    // Storage write; no reset is needed for the array.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= push_data;
    end

    // Pointer and fill count update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            fill <= fill + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    a_r2_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(DEPTH));
    a_r4_drop_holds_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (push && is_full && !pop) |=> (fill == $past(fill)));
    a_r3_empty_pop_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && is_empty && !push) |=> (fill == '0));
endmodule

// File: rtl/rxq_flags.sv
// Module: rxq_flags
// Three sticky event flags with write-one-to-clear and the interrupt output.
// A set condition in the same cycle wins over a clear.
// Assumes: clear strobes are already decoded to one bit per flag.
module rxq_flags #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drop_evt,
    input  logic             pkt_evt,
    input  logic [CNT_W-1:0] fill,
    input  logic [CNT_W-1:0] level,
    input  logic             clr_ovf,
    input  logic             clr_pend,
    input  logic             clr_avail,
    input  logic             en_ovf,
    input  logic             en_pend,
    input  logic             en_avail,
    output logic             ovf_q,
    output logic             pend_q,
    output logic             avail_q,
    output logic             irq
);
    logic above;

    // Trigger comparison: strictly above the level.
    always_comb above = (fill > level);

    // Sticky flag update, set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q   <= 1'b0;
            pend_q  <= 1'b0;
            avail_q <= 1'b0;
        end else begin
            ovf_q   <= drop_evt | (ovf_q   & ~clr_ovf);
            pend_q  <= pkt_evt  | (pend_q  & ~clr_pend);
            avail_q <= above    | (avail_q & ~clr_avail);
        end
    end

    // Interrupt: any enabled flag.
    always_comb irq = (ovf_q & en_ovf) | (pend_q & en_pend) | (avail_q & en_avail);

    a_r4_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        drop_evt |=> ovf_q);
    a_r5_pend_sets: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_evt |=> pend_q);
    a_r6_avail_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (fill > level) |=> avail_q);
    a_r7_pend_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pend && !pkt_evt) |=> !pend_q);
    a_r7_ovf_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ovf && !drop_evt) |=> !ovf_q);
endmodule

// File: rtl/rxq_irq_top.sv
// Module: rxq_irq_top
// Register front end for the receive byte queue: data pop, enable/trigger
// register, status with write-one-to-clear, registered read data.
// Assumes: reads and writes are single-cycle strobes; a write and a read in
// the same cycle are both honoured.
module rxq_irq_top
    import rxq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    parameter int REG_W  = 32,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_byte_vld,
    input  logic [DATA_W-1:0] in_byte,
    input  logic              in_pkt_end,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_rd,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    logic              en_ovf, en_pend, en_avail;
    logic [CNT_W-1:0]  level;
    logic              pop;
    logic [DATA_W-1:0] pop_data;
    logic [CNT_W-1:0]  fill;
    logic              drop;
    logic              st_wr;
    logic              ovf_q, pend_q, avail_q;
    logic [REG_W-1:0]  rd_word;
    logic              wdata_unused;

    always_comb wdata_unused = ^reg_wdata;

    // Decode strobes from the register select.
    always_comb begin
        pop   = reg_rd && (reg_sel_e'(reg_addr) == SEL_DATA);
        st_wr = reg_wr && (reg_sel_e'(reg_addr) == SEL_STATUS);
    end

    rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (in_byte_vld),
        .push_data (in_byte),
        .pop       (pop),
        .pop_data  (pop_data),
        .fill      (fill),
        .drop      (drop)
    );

    rxq_flags #(.CNT_W(CNT_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .drop_evt  (drop),
        .pkt_evt   (in_pkt_end),
        .fill      (fill),
        .level     (level),
        .clr_ovf   (st_wr && reg_wdata[OVF_POS]),
        .clr_pend  (st_wr && reg_wdata[PEND_POS]),
        .clr_avail (st_wr && reg_wdata[AVAIL_POS]),
        .en_ovf    (en_ovf),
        .en_pend   (en_pend),
        .en_avail  (en_avail),
        .ovf_q     (ovf_q),
        .pend_q    (pend_q),
        .avail_q   (avail_q),
        .irq       (irq)
    );

    // Enable and trigger-level register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_ovf   <= 1'b0;
            en_pend  <= 1'b0;
            en_avail <= 1'b0;
            level    <= '0;
        end else if (reg_wr && (reg_sel_e'(reg_addr) == SEL_ENABLE)) begin
            en_ovf   <= reg_wdata[OVF_POS];
            en_pend  <= reg_wdata[PEND_POS];
            en_avail <= reg_wdata[AVAIL_POS];
            level    <= reg_wdata[FIELD_POS +: CNT_W];
        end
    end

    // Read multiplexer over the register map.
    always_comb begin
        rd_word = '0;
        case (reg_sel_e'(reg_addr))
            SEL_DATA: rd_word[DATA_W-1:0] = pop_data;
            SEL_ENABLE: begin
                rd_word[OVF_POS]              = en_ovf;
                rd_word[PEND_POS]             = en_pend;
                rd_word[AVAIL_POS]            = en_avail;
                rd_word[FIELD_POS +: CNT_W]   = level;
            end
            SEL_STATUS: begin
                rd_word[OVF_POS]              = ovf_q;
                rd_word[PEND_POS]             = pend_q;
                rd_word[AVAIL_POS]            = avail_q;
                rd_word[FIELD_POS +: CNT_W]   = fill;
            end
            default: rd_word = '0;
        endcase
    end

    // Registered read data, zero when no read was made.
    always_ff @(posedge clk) begin
        if (!rst_n) reg_rdata <= '0;
        else        reg_rdata <= reg_rd ? rd_word : '0;
    end

    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> (reg_rdata == '0));
    a_r9_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == 2'd3) |=> (reg_rdata == '0));
endmodule

// File: tb/tb_rxq_irq_top.sv
// Scoreboard bench for rxq_irq_top: the driver records accepted bytes in a
// queue; a monitor compares every data-register read against it.
module tb_rxq_irq_top;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_byte_vld = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_pkt_end = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [31:0] reg_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_q[$];
    logic mon_arm = 1'b0;

    always #4 clk = ~clk;

    rxq_irq_top #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .in_byte_vld(in_byte_vld), .in_byte(in_byte),
        .in_pkt_end(in_pkt_end), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: after each data read, compare against the scoreboard (R2, R3).
    always @(posedge clk) mon_arm <= reg_rd && (reg_addr == 2'd0);
    always @(negedge clk) begin
        if (mon_arm) begin
            logic [7:0] e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
            check("R2/R3 data order", reg_rdata, {24'h0, e});
        end
    end

    task automatic reg_write(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd = 1'b0;
        v = reg_rdata;
    endtask

    // Driver: push one byte, record it in the scoreboard if it fits.
    task automatic push(logic [7:0] b);
        @(negedge clk);
        in_byte_vld = 1'b1; in_byte = b;
        if (exp_q.size() < DEPTH) exp_q.push_back(b);
        @(negedge clk);
        in_byte_vld = 1'b0;
    endtask

    task automatic pop_one();
        logic [31:0] v;
        reg_read(2'd0, v);
    endtask

    task automatic pkt_pulse();
        @(negedge clk);
        in_pkt_end = 1'b1;
        @(negedge clk);
        in_pkt_end = 1'b0;
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq", {31'h0, irq}, 32'h0);
        check("R10 rdata idle", reg_rdata, 32'h0);
        reg_read(2'd2, v); check("R1 status", v, 32'h0);
        reg_read(2'd1, v); check("R1 enable", v, 32'h0);

        reg_write(2'd1, 32'h0000_0700);
        reg_read(2'd1, v); check("R9 enable readback", v, 32'h0000_0700);

        push(8'hA1); push(8'hB2); push(8'hC3);
        reg_read(2'd2, v); check("R2 count 3, R6 no avail", v, 32'h0000_0300);
        for (int i = 0; i < 3; i++) pop_one();
        pop_one(); // empty read, R3
        reg_read(2'd2, v); check("R3 empty count", v, 32'h0);

        for (int i = 0; i < 7; i++) push(8'h10 + 8'(i));
        reg_read(2'd2, v); check("R6 at level", v, 32'h0000_0700);
        push(8'h17);
        reg_read(2'd2, v); check("R6 above level", v, 32'h0000_0810);
        check("R8 irq disabled", {31'h0, irq}, 32'h0);

        reg_write(2'd1, 32'h0000_0710);
        check("R8 irq enabled", {31'h0, irq}, 32'h1);
        reg_write(2'd2, 32'h0000_0010);
        reg_read(2'd2, v); check("R7 avail reasserts", v, 32'h0000_0810);

        pop_one(); pop_one();
        reg_write(2'd2, 32'h0000_0010);
        reg_read(2'd2, v); check("R7 avail cleared", v, 32'h0000_0600);
        check("R8 irq low", {31'h0, irq}, 32'h0);

        pkt_pulse();
        reg_read(2'd2, v); check("R5 pkt end", v, 32'h0000_0602);
        check("R8 pend not enabled", {31'h0, irq}, 32'h0);
        reg_write(2'd1, 32'h0000_0712);
        check("R8 pend enabled", {31'h0, irq}, 32'h1);
        reg_write(2'd2, 32'h0000_0001);
        reg_read(2'd2, v); check("R7 other bit kept", v, 32'h0000_0602);
        reg_write(2'd2, 32'h0000_0002);
        reg_read(2'd2, v); check("R7 pend cleared", v, 32'h0000_0600);

        for (int i = 0; i < 10; i++) push(8'h40 + 8'(i));
        push(8'hEE); // dropped, R4
        reg_read(2'd2, v); check("R4 overflow full", v, 32'h0000_1011);
        for (int i = 0; i < DEPTH; i++) pop_one();
        pop_one();
        pkt_pulse();
        reg_read(2'd2, v); check("R4 drained flags", v, 32'h0000_0013);
        reg_write(2'd2, 32'h0000_00FF);
        reg_read(2'd2, v); check("R7 clear all", v, 32'h0);

        push(8'h55); push(8'h66);
        reg_write(2'd2, 32'h0000_1F00);
        reg_read(2'd2, v); check("R7 count write ignored", v, 32'h0000_0200);
        reg_read(2'd3, v); check("R9 spare zero", v, 32'h0);
        @(negedge clk);
        check("R10 rdata idle", reg_rdata, 32'h0);
        pop_one(); pop_one();
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule